// File: doc/BRIEF.md
# Multi-Region Image Histogram Engine

This block builds intensity histograms from a raw camera pixel stream. Every pixel arrives with frame, line and valid markers and a two-bit colour-phase code. The engine multiplies the pixel by a white-balance gain chosen by its colour phase, saturates the result to the input range and shifts it down to a bin index. It then increments that bin for each rectangular region, out of up to four, that contains the pixel. All regions share one 256-word result store, so a larger region count leaves fewer bins for each region.

Software programs the region rectangles, the bin count, the colour-filter mode, the gains and an enable through a small register port. The same port reads results out through an auto-incrementing pointer. A clear-on-read control zeroes each word as it is returned, so one full sweep both collects a histogram and empties the store. A busy output shows that a frame is being accumulated. Configuration written during a frame is held back and applied at the next frame start.

Top module: `imghist_core`

## Requirements
- R1: After reset every result word reads 0, the readout pointer is 0 and `busy` is low.
- R2: The gained value is min(1023, (pixel x gain) >> 5). The gain is an unsigned 8-bit value with 5 fraction bits (0x20 is unity). Gain register 1 holds the gain for colour phase p in bits [8p+7:8p].
- R3: Control bits [3:2] pick the bin count: 0 gives 256, 1 gives 128, 2 gives 64, 3 gives 32. The bin index is the gained value shifted right by 10 minus log2 of the bin count.
- R4: Column and row count from 0. Column counts valid pixels since the line marker rose, and row counts completed lines since the frame marker rose. A pixel hits region r when hstart <= column <= hend and vstart <= row <= vend, both bounds inclusive. Register 4+2r holds the horizontal bounds and register 5+2r the vertical bounds, start in bits [9:0] and end in bits [25:16].
- R5: Region r's bin b is stored at word r x bins + b.
- R6: A pixel that lies inside several regions increments its bin in each of those regions.
- R7: Control bits [5:4] hold the region count minus one. Regions at or above the count never accumulate, whatever their bounds.
- R8: The bin count is capped by the region count: 256 for one region, 128 for two, 64 for three or four. A larger request falls back to that cap.
- R9: Each counter saturates at 2^CNT_W-1 and does not wrap.
- R10: Writing register 2 loads the readout pointer. Each read of register 3 returns the word at the pointer and advances the pointer by one, wrapping from 255 to 0. Read data appears on `reg_rdata` one clock after the read strobe, and a read of register 2 returns the pointer.
- R11: When control bit 1 is set, a data read zeroes the word it returns. When the bit is clear, the word is left unchanged.
- R12: Control bit 6 selects three-colour stacked mode. In that mode phase-3 pixels use unity gain and gain byte 3 is ignored. In Bayer mode (bit 6 = 0) all four gains apply.
- R13: Control bit 0 enables accumulation for the frames that start after it is set. `busy` rises on the first pixel accepted in an enabled frame and falls when the frame marker drops. A frame that starts while the engine is disabled changes no word and leaves `busy` low.
- R14: Control, gain and region writes made while a frame is open take effect at the next rise of the frame marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_frame | input | 1 | High for the duration of a frame |
| px_line | input | 1 | High for the duration of a line |
| px_valid | input | 1 | Pixel data valid this cycle |
| px_phase | input | 2 | Colour phase of the pixel |
| px_data | input | 10 | Raw pixel value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| busy | output | 1 | Frame accumulation in progress |

## Verification
The bench targets overlapping rectangles that share rows and columns. A design that stops at the first matching region would undercount the second region. A design with exclusive bounds would return 6 or 4 instead of 8. Asking for 256 bins with three regions exposes a missing cap, because the counts would land at word 255 instead of 63, 127 and 191. Changing the bin count halfway through a frame shows whether configuration leaks into the open frame. Reading the same word twice, with and without clear-on-read, shows whether clearing is tied to the control bit. Phase-3 pixels in both colour modes separate the stacked-mode unity gain from the fourth gain. A long run of identical pixels at a reduced counter width shows whether a counter wraps instead of saturating.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int PIX_W       = 10;
  localparam int GAIN_W      = 8;
  localparam int GAIN_FRAC   = 5;
  localparam int NREG        = 4;
  localparam int PHASES      = 4;
  localparam int COORD_W     = 10;
  localparam int BIN_LOG_MAX = 8;
  localparam int MEM_DEPTH   = 1 << BIN_LOG_MAX;
  localparam int ADDR_W      = $clog2(MEM_DEPTH);
  localparam int REG_W       = $clog2(NREG);
  localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1 << GAIN_FRAC);

  localparam logic [3:0] RA_CTRL = 4'd0;
  localparam logic [3:0] RA_GAIN = 4'd1;
  localparam logic [3:0] RA_PTR  = 4'd2;
  localparam logic [3:0] RA_DATA = 4'd3;
  localparam logic [3:0] RA_REG0 = 4'd4;

  typedef struct packed {
    logic                                en;
    logic                                stacked;
    logic [1:0]                          bsel;
    logic [1:0]                          nrm1;
    logic [PHASES-1:0][GAIN_W-1:0]       gain;
    logic [NREG-1:0][COORD_W-1:0]        hs;
    logic [NREG-1:0][COORD_W-1:0]        he;
    logic [NREG-1:0][COORD_W-1:0]        vs;
    logic [NREG-1:0][COORD_W-1:0]        ve;
  } cfg_t;

  // Multiply by a 3.5 gain, drop the fraction, saturate to the input range.
  function automatic logic [PIX_W-1:0] apply_gain(input logic [PIX_W-1:0] pix,
                                                  input logic [GAIN_W-1:0] g);
    logic [PIX_W+GAIN_W-1:0] prod;
    logic [PIX_W+GAIN_W-GAIN_FRAC-1:0] scaled;
    prod   = {{GAIN_W{1'b0}}, pix} * {{PIX_W{1'b0}}, g};
    scaled = prod[PIX_W+GAIN_W-1:GAIN_FRAC];
    if (|scaled[PIX_W+GAIN_W-GAIN_FRAC-1:PIX_W]) return '1;
    return scaled[PIX_W-1:0];
  endfunction

  // Smallest legal bin selector for a region count (bigger selector = fewer bins).
  function automatic logic [1:0] clamp_sel(input logic [1:0] bsel, input logic [1:0] nrm1);
    logic [1:0] lo;
    lo = (nrm1 == 2'd0) ? 2'd0 : (nrm1 == 2'd1) ? 2'd1 : 2'd2;
    return (bsel < lo) ? lo : bsel;
  endfunction

  function automatic logic [ADDR_W-1:0] bin_index(input logic [PIX_W-1:0] g,
                                                  input logic [1:0] sel);
    logic [PIX_W-1:0] s;
    s = g >> (PIX_W - BIN_LOG_MAX + int'(sel));
    return s[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [REG_W-1:0] r,
                                                  input logic [ADDR_W-1:0] bin,
                                                  input logic [1:0] sel);
    logic [ADDR_W-1:0] base;
    base = ADDR_W'(r) << (BIN_LOG_MAX - int'(sel));
    return base | bin;
  endfunction
endpackage

// File: rtl/hist_pos_track.sv
module hist_pos_track
  import hist_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               px_frame,
  input  logic               px_line,
  input  logic               px_valid,
  output logic [COORD_W-1:0] col,
  output logic [COORD_W-1:0] row,
  output logic               frame_rise
);
  logic frame_q, line_q;
  logic line_fall;

  assign frame_rise = px_frame & ~frame_q;
  assign line_fall  = line_q & ~px_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      line_q  <= 1'b0;
      col     <= '0;
      row     <= '0;
    end else begin
      frame_q <= px_frame;
      line_q  <= px_line;
      if (!px_line)      col <= '0;
      else if (px_valid) col <= col + 1'b1;
      if (!px_frame)     row <= '0;
      else if (line_fall) row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/hist_region_match.sv
module hist_region_match
  import hist_pkg::*;
(
  input  logic [COORD_W-1:0] hs,
  input  logic [COORD_W-1:0] he,
  input  logic [COORD_W-1:0] vs,
  input  logic [COORD_W-1:0] ve,
  input  logic [COORD_W-1:0] col,
  input  logic [COORD_W-1:0] row,
  input  logic               allow,
  output logic               hit
);
  always_comb begin
    hit = allow && (col >= hs) && (col <= he) && (row >= vs) && (row <= ve);
  end
endmodule

// File: rtl/hist_store.sv
module hist_store
  import hist_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        upd_valid,
  input  logic [NREG-1:0]             upd_hit,
  input  logic [NREG-1:0][ADDR_W-1:0] upd_addr,
  input  logic                        ptr_wr,
  input  logic [ADDR_W-1:0]           ptr_wdata,
  input  logic                        rd_take,
  input  logic                        rd_clear,
  output logic [CNT_W-1:0]            rd_word,
  output logic [ADDR_W-1:0]           ptr
);
  logic [CNT_W-1:0] mem [MEM_DEPTH];

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  assign rd_word = mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
      ptr <= '0;
    end else begin
      if (rd_take && rd_clear) mem[ptr] <= '0;
      if (upd_valid) begin
        for (int r = 0; r < NREG; r++) begin
          if (upd_hit[r]) mem[upd_addr[r]] <= sat_inc(mem[upd_addr[r]]);
        end
      end
      if (ptr_wr)       ptr <= ptr_wdata;
      else if (rd_take) ptr <= ptr + 1'b1;
    end
  end

  // R10
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !ptr_wr) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/imghist_core.sv
module imghist_core
  import hist_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             px_frame,
  input  logic             px_line,
  input  logic             px_valid,
  input  logic [1:0]       px_phase,
  input  logic [PIX_W-1:0] px_data,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             busy
);
  localparam logic [3:0] RA_LAST = RA_REG0 + 4'(2 * NREG);

  cfg_t sh, act, cur;
  logic clr_on_rd;
  logic [COORD_W-1:0] col, row;
  logic frame_rise;

  logic [3:0]       reg_off;
  logic [REG_W-1:0] ridx;
  logic             is_region;

  assign reg_off   = reg_addr - RA_REG0;
  assign ridx      = reg_off[REG_W:1];
  assign is_region = (reg_addr >= RA_REG0) && (reg_addr < RA_LAST);

  // Shadow configuration written by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      sh.gain   <= {PHASES{GAIN_ONE}};
      clr_on_rd <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == RA_CTRL) begin
        sh.en      <= reg_wdata[0];
        clr_on_rd  <= reg_wdata[1];
        sh.bsel    <= reg_wdata[3:2];
        sh.nrm1    <= reg_wdata[5:4];
        sh.stacked <= reg_wdata[6];
      end else if (reg_addr == RA_GAIN) begin
        sh.gain <= reg_wdata;
      end else if (is_region) begin
        if (!reg_off[0]) begin
          sh.hs[ridx] <= reg_wdata[COORD_W-1:0];
          sh.he[ridx] <= reg_wdata[16+COORD_W-1:16];
        end else begin
          sh.vs[ridx] <= reg_wdata[COORD_W-1:0];
          sh.ve[ridx] <= reg_wdata[16+COORD_W-1:16];
        end
      end
    end
  end

  hist_pos_track u_pos (
    .clk(clk), .rst_n(rst_n), .px_frame(px_frame), .px_line(px_line),
    .px_valid(px_valid), .col(col), .row(row), .frame_rise(frame_rise)
  );

  // Active configuration: captured at frame start, bypassed on that cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= '0;
      act.gain <= {PHASES{GAIN_ONE}};
    end else if (frame_rise) begin
      act <= sh;
    end
  end
  assign cur = frame_rise ? sh : act;

  // Pixel datapath
  logic                        pix_take;
  logic [GAIN_W-1:0]           gain_sel;
  logic [PIX_W-1:0]            gained;
  logic [1:0]                  sel_eff;
  logic [ADDR_W-1:0]           bin;
  logic [NREG-1:0]             hit_raw;
  logic [NREG-1:0][ADDR_W-1:0] addr_c;

  assign pix_take = px_frame && px_line && px_valid && cur.en;
  assign gain_sel = (cur.stacked && px_phase == 2'd3) ? GAIN_ONE : cur.gain[px_phase];
  assign gained   = apply_gain(px_data, gain_sel);
  assign sel_eff  = clamp_sel(cur.bsel, cur.nrm1);
  assign bin      = bin_index(gained, sel_eff);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    hist_region_match u_match (
      .hs(cur.hs[r]), .he(cur.he[r]), .vs(cur.vs[r]), .ve(cur.ve[r]),
      .col(col), .row(row),
      .allow(REG_W'(r) <= cur.nrm1),
      .hit(hit_raw[r])
    );
    assign addr_c[r] = word_addr(REG_W'(r), bin, sel_eff);
  end

  logic                        s1_valid;
  logic [NREG-1:0]             s1_hit;
  logic [NREG-1:0][ADDR_W-1:0] s1_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= '0;
      s1_addr  <= '0;
      busy     <= 1'b0;
    end else begin
      s1_valid <= pix_take;
      s1_hit   <= pix_take ? hit_raw : '0;
      s1_addr  <= addr_c;
      if (!px_frame)     busy <= 1'b0;
      else if (pix_take) busy <= 1'b1;
    end
  end

  logic [CNT_W-1:0]  rd_word;
  logic [ADDR_W-1:0] ptr;

  hist_store #(.CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(s1_valid), .upd_hit(s1_hit), .upd_addr(s1_addr),
    .ptr_wr(reg_wr && reg_addr == RA_PTR), .ptr_wdata(reg_wdata[ADDR_W-1:0]),
    .rd_take(reg_rd && reg_addr == RA_DATA), .rd_clear(clr_on_rd),
    .rd_word(rd_word), .ptr(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_CTRL: reg_rdata <= {busy, 24'b0, sh.stacked, sh.nrm1, sh.bsel, clr_on_rd, sh.en};
        RA_GAIN: reg_rdata <= sh.gain;
        RA_PTR:  reg_rdata <= 32'(ptr);
        RA_DATA: reg_rdata <= 32'(rd_word);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R13
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(px_frame && px_line && px_valid));
  // R13
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(px_frame));

  for (genvar r = 0; r < NREG; r++) begin : g_chk
    // R7
    unused_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_hit[r] |-> ($past(cur.nrm1) >= REG_W'(r)));
    for (genvar b = r + 1; b < NREG; b++) begin : g_pair
      // R5
      distinct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_hit[r] && s1_hit[b]) |-> (s1_addr[r] != s1_addr[b]));
    end
  end
endmodule

// File: tb/imghist_core_tb.sv
`timescale 1ns/1ps
module imghist_core_tb;
  localparam int CW = 6;
  localparam logic [3:0] A_CTRL = 4'd0, A_GAIN = 4'd1, A_PTR = 4'd2, A_DATA = 4'd3;
  localparam logic [31:0] FULL = (32'd1023 << 16);

  logic clk = 1'b0, rst_n = 1'b0;
  logic px_frame = 0, px_line = 0, px_valid = 0;
  logic [1:0] px_phase = 0;
  logic [9:0] px_data = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic busy;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  imghist_core #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .px_frame(px_frame), .px_line(px_line),
    .px_valid(px_valid), .px_phase(px_phase), .px_data(px_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
  );

  // {pixel, phase, gain, bin select, stacked, expected bin}
  localparam logic [30:0] VEC [8] = '{
    {10'd512,  2'd0, 8'h20, 2'd0, 1'b0, 8'd128},
    {10'd1023, 2'd0, 8'h40, 2'd0, 1'b0, 8'd255},
    {10'd300,  2'd0, 8'h30, 2'd1, 1'b0, 8'd56},
    {10'd100,  2'd1, 8'h10, 2'd3, 1'b0, 8'd1},
    {10'd640,  2'd2, 8'h28, 2'd2, 1'b0, 8'd50},
    {10'd400,  2'd3, 8'h08, 2'd0, 1'b1, 8'd100},
    {10'd400,  2'd3, 8'h08, 2'd0, 1'b0, 8'd25},
    {10'd7,    2'd0, 8'hFF, 2'd0, 1'b0, 8'd13}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; v = int'(reg_rdata);
  endtask

  task automatic read_word(input int idx, output int v);
    wr(A_PTR, 32'(idx));
    rd(A_DATA, v);
  endtask

  task automatic ctrl(input bit en, input bit clr, input int bsel, input int nrm1, input bit stk);
    wr(A_CTRL, 32'(en) | (32'(clr) << 1) | (32'(bsel) << 2) | (32'(nrm1) << 4) | (32'(stk) << 6));
  endtask

  task automatic frame_begin();
    @(negedge clk); px_frame = 1;
    @(negedge clk);
  endtask

  task automatic frame_end();
    @(negedge clk); px_frame = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic line(input int n, input int val, input int ph);
    @(negedge clk);
    px_line = 1;
    for (int i = 0; i < n; i++) begin
      px_valid = 1; px_data = 10'(val); px_phase = 2'(ph);
      @(negedge clk);
    end
    px_valid = 0; px_line = 0;
    @(negedge clk);
  endtask

  initial begin
    int v;
    logic [31:0] gw;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy after reset", int'(busy), 0);
    read_word(0, v);   check("R1 word 0 after reset", v, 0);
    read_word(200, v); check("R1 word 200 after reset", v, 0);

    // R2 R3 R12 gain and bin table
    wr(4'd4, FULL); wr(4'd5, FULL);
    for (int k = 0; k < 8; k++) begin
      gw = 32'h20202020;
      gw[8*int'(VEC[k][20:19]) +: 8] = VEC[k][18:11];
      wr(A_GAIN, gw);
      ctrl(1, 1, int'(VEC[k][10:9]), 0, VEC[k][8]);
      frame_begin();
      line(1, int'(VEC[k][30:21]), int'(VEC[k][20:19]));
      frame_end();
      read_word(int'(VEC[k][7:0]), v);
      check("R2 R3 R12 table bin count", v, 1);
      rd(A_DATA, v);
      check("R3 table neighbour word", v, 0);
    end
    wr(A_GAIN, 32'h20202020);

    // R4 R5 R6 R7 R8 overlapping regions, 3 regions with 256 bins requested
    wr(4'd4, (32'd3 << 16) | 32'd0);  wr(4'd5, (32'd1 << 16) | 32'd0);
    wr(4'd6, (32'd5 << 16) | 32'd2);  wr(4'd7, (32'd2 << 16) | 32'd1);
    wr(4'd8, (32'd10 << 16) | 32'd10); wr(4'd9, 32'd0);
    wr(4'd10, FULL); wr(4'd11, FULL);
    ctrl(1, 1, 0, 2, 0);
    frame_begin();
    check("R13 busy before first pixel", int'(busy), 0);
    for (int l = 0; l < 3; l++) line(12, 1023, 0);
    check("R13 busy during frame", int'(busy), 1);
    frame_end();
    check("R13 busy after frame", int'(busy), 0);
    read_word(63, v);  check("R4 R8 region0 count", v, 8);
    read_word(127, v); check("R6 region1 overlap count", v, 8);
    read_word(191, v); check("R5 region2 count", v, 1);
    read_word(255, v); check("R7 region3 unused", v, 0);

    // R14 mid-frame configuration change
    wr(4'd4, FULL); wr(4'd5, FULL);
    ctrl(1, 1, 0, 0, 0);
    frame_begin();
    line(1, 1023, 0);
    ctrl(1, 1, 3, 0, 0);
    line(1, 1023, 0);
    frame_end();
    read_word(255, v); check("R14 old bins kept in open frame", v, 2);
    frame_begin(); line(1, 1023, 0); frame_end();
    read_word(31, v);  check("R14 new bins next frame", v, 1);
    read_word(255, v); check("R14 old bin untouched", v, 0);

    // R11 clear-on-read control
    ctrl(1, 0, 0, 0, 0);
    frame_begin(); line(1, 512, 0); frame_end();
    read_word(128, v); check("R11 read without clear", v, 1);
    read_word(128, v); check("R11 word retained", v, 1);
    ctrl(1, 1, 0, 0, 0);
    read_word(128, v); check("R11 read with clear", v, 1);
    read_word(128, v); check("R11 word cleared", v, 0);

    // R10 pointer wrap
    frame_begin(); line(1, 0, 0); frame_end();
    read_word(255, v); check("R10 word 255", v, 0);
    rd(A_DATA, v);     check("R10 wrap to word 0", v, 1);
    rd(A_PTR, v);      check("R10 pointer after wrap", v, 1);

    // R13 disabled frame
    ctrl(0, 1, 0, 0, 0);
    frame_begin(); line(3, 512, 0);
    check("R13 busy stays low when disabled", int'(busy), 0);
    frame_end();
    read_word(128, v); check("R13 disabled frame no count", v, 0);

    // R9 counter saturation
    ctrl(1, 1, 0, 0, 0);
    frame_begin(); line(70, 4, 0); frame_end();
    read_word(1, v); check("R9 saturated counter", v, (1 << CW) - 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule